// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out exception entry for a small processor core with 16-bit data words and 32-bit addresses. The core raises a request with a cause code, the current status word, the program counter and the supervisor stack pointer. The sequencer first takes a temporary copy of the status word and switches the core to supervisor state. It then resolves the vector number and pushes the return context onto the supervisor stack. Last, it reads the handler address from the vector table and returns the new program counter, stack pointer and status word with a one-cycle completion pulse.

A reset entry is handled differently. It pushes nothing and reads four words from program space: the initial stack pointer and the initial program counter. All memory traffic goes through one word-wide request/acknowledge port. The block also holds the core's privilege bit. Only an exception entry can set that bit, while a status write can clear it but never set it.

Top module: `exc_entry_seq`

## Requirements
- R1: Cause code 0 selects vector 0 (reset), and cause codes 1 to 9 select vector code+1: bus error 2, address error 3, illegal instruction 4, divide by zero 5, bounds check 6, overflow trap 7, privilege violation 8, trace 9, line 1010 opcode 10.
- R2: Cause codes 10 to 15 take the vector number from `ext_vec_i`. For any other code, `ext_vec_i` has no effect.
- R3: A non-reset entry reads two words in supervisor data space (space code 5): first at vector*4, which is the high half of the handler address, then at vector*4+2, which is the low half. `new_pc_o` is {first, second}.
- R4: A non-reset entry first writes three words in space 5, with no reads in between. The low PC word goes to ssp-2, the high PC word to ssp-4 and the saved status to ssp-6. `new_ssp_o` is ssp-6.
- R5: The saved status equals `sr_i` with bit 13 (S) replaced by the tracked privilege bit. `new_sr_o` is the saved status with bit 13 set.
- R6: A reset entry (cause 0) writes nothing. It reads program space (space code 6) at addresses 0, 2, 4 and 6. `new_ssp_o` is {word0, word1} cut to the address width, `new_pc_o` is {word2, word3}, and `new_sr_o` is 16'h2700.
- R7: While `mem_req_o` is high and `mem_ack_i` is low, the address, write data, write enable and space code do not change.
- R8: A request is accepted on a clock edge where `req_i` is high and `busy_o` is low. `busy_o` rises after that edge. The first memory request appears after the second edge. `done_o` is high for exactly one cycle, with valid `new_pc_o`, `new_ssp_o` and `new_sr_o`. `busy_o` is low in the cycle after `done_o`.
- R9: While `busy_o` is high, `req_i` and changes on `cause_i`, `sr_i`, `pc_i` and `ssp_i` have no effect on the running entry.
- R10: `supervisor_o` is 1 after reset and becomes 1 on every accepted request. A status write (`sr_wr_i`) sets it to its current value ANDed with bit 13 of `sr_wdata_i`, so a write can clear it but never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Exception entry request |
| cause_i | input | 4 | Cause code |
| ext_vec_i | input | VEC_W | Vector number for external causes |
| sr_i | input | 16 | Current status word |
| pc_i | input | 32 | Return program counter |
| ssp_i | input | ADDR_W | Current supervisor stack pointer |
| sr_wr_i | input | 1 | Status write strobe |
| sr_wdata_i | input | 16 | Status write value |
| busy_o | output | 1 | Entry sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| new_pc_o | output | 32 | Handler program counter |
| new_ssp_o | output | ADDR_W | Stack pointer after entry |
| new_sr_o | output | 16 | Status word for the handler |
| supervisor_o | output | 1 | Tracked privilege bit |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_space_o | output | 3 | Address space code |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 16 | Read data |

## Verification
The hardest case to reach from the ports is a second request that arrives during a running entry and changes the cause, status, PC and stack pointer inputs mid-sequence. It has to leave the frame and the result untouched. The stimulus table has an entry that holds `req_i` high with altered inputs from the cycle after acceptance until the pushes are under way. The bench then compares every logged access and the results with values computed from the original inputs. Each table entry also runs with a different acknowledge latency, so the hold rule is exercised during real wait states. A status write with S flipped before each entry means the saved status can only match if the tracked bit, and not `sr_i[13]`, is stacked.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_VEC, ST_PUSH, ST_FETCH, ST_FIN} seq_st_e;

  localparam logic [2:0]  SPACE_SD    = 3'd5;
  localparam logic [2:0]  SPACE_SP    = 3'd6;
  localparam logic [3:0]  CAUSE_RESET = 4'd0;
  localparam logic [3:0]  CAUSE_EXT   = 4'd10;
  localparam int          SR_S_BIT    = 13;
  localparam logic [15:0] SR_S_MASK   = 16'h2000;
  localparam logic [15:0] SR_RESET    = 16'h2700;
endpackage

// File: rtl/exc_vec_map.sv
module exc_vec_map import exc_pkg::*; #(
  parameter int VEC_W = 8
) (
  input  logic [3:0]       cause_i,
  input  logic [VEC_W-1:0] ext_vec_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             is_reset_o
);
  always_comb begin
    is_reset_o = (cause_i == CAUSE_RESET);
    if (cause_i >= CAUSE_EXT)  vec_o = ext_vec_i;
    else if (is_reset_o)       vec_o = '0;
    else                       vec_o = VEC_W'(cause_i) + VEC_W'(1);
  end
endmodule

// File: rtl/exc_priv_track.sv
module exc_priv_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic wr_i,
  input  logic wr_s_i,
  output logic s_o
);
  logic s_q;

  // entry wins over a same-cycle write; a write can only clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      s_q <= 1'b1;
    else if (enter_i) s_q <= 1'b1;
    else if (wr_i)    s_q <= s_q & wr_s_i;
  end

  assign s_o = s_q;
endmodule

// File: rtl/exc_frame_mux.sv
module exc_frame_mux import exc_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int VEC_W  = 8
) (
  input  seq_st_e           st_i,
  input  logic [1:0]        idx_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              is_reset_i,
  input  logic [31:0]       pc_i,
  input  logic [15:0]       sr_i,
  output logic              we_o,
  output logic [2:0]        space_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [15:0]       wdata_o
);
  localparam int OFS_W = VEC_W + 2;

  logic [ADDR_W-1:0] base;
  logic [OFS_W-1:0]  ofs;

  assign ofs  = {vec_i, 2'b00};
  assign base = ADDR_W'(ofs);

  always_comb begin
    we_o    = (st_i == ST_PUSH);
    addr_o  = we_o ? sp_i : base + ADDR_W'({idx_i, 1'b0});
    space_o = (st_i == ST_FETCH && is_reset_i) ? SPACE_SP : SPACE_SD;
    unique case (idx_i)
      2'd0:    wdata_o = pc_i[15:0];
      2'd1:    wdata_o = pc_i[31:16];
      default: wdata_o = sr_i;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq import exc_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [3:0]        cause_i,
  input  logic [VEC_W-1:0]  ext_vec_i,
  input  logic [15:0]       sr_i,
  input  logic [31:0]       pc_i,
  input  logic [ADDR_W-1:0] ssp_i,
  input  logic              sr_wr_i,
  input  logic [15:0]       sr_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       new_pc_o,
  output logic [ADDR_W-1:0] new_ssp_o,
  output logic [15:0]       new_sr_o,
  output logic              supervisor_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [2:0]        mem_space_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [15:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [15:0]       mem_rdata_i
);
  localparam int WORD_W  = 16;
  localparam int FETCH_W = 4 * WORD_W;

  seq_st_e            st_q;
  logic [1:0]         idx_q;
  logic [ADDR_W-1:0]  sp_q;
  logic [31:0]        pc_q;
  logic [15:0]        sr_q;
  logic [3:0]         cause_q;
  logic [VEC_W-1:0]   ext_q, vec_q, vec_d;
  logic [FETCH_W-1:0] fetch_q;
  logic               is_reset, enter, s_cur;
  logic [1:0]         last_idx;

  assign enter    = (st_q == ST_IDLE) && req_i;
  assign last_idx = is_reset ? 2'd3 : 2'd1;

  exc_vec_map #(.VEC_W(VEC_W)) u_map (
    .cause_i    (cause_q),
    .ext_vec_i  (ext_q),
    .vec_o      (vec_d),
    .is_reset_o (is_reset)
  );

  exc_priv_track u_priv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enter_i (enter),
    .wr_i    (sr_wr_i),
    .wr_s_i  (sr_wdata_i[SR_S_BIT]),
    .s_o     (s_cur)
  );

  exc_frame_mux #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_mux (
    .st_i       (st_q),
    .idx_i      (idx_q),
    .sp_i       (sp_q),
    .vec_i      (vec_q),
    .is_reset_i (is_reset),
    .pc_i       (pc_q),
    .sr_i       (sr_q),
    .we_o       (mem_we_o),
    .space_o    (mem_space_o),
    .addr_o     (mem_addr_o),
    .wdata_o    (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      sp_q    <= '0;
      pc_q    <= '0;
      sr_q    <= '0;
      cause_q <= CAUSE_RESET;
      ext_q   <= '0;
      vec_q   <= '0;
      fetch_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_i) begin
          // phase 1: temporary status copy carries the old S
          cause_q <= cause_i;
          ext_q   <= ext_vec_i;
          pc_q    <= pc_i;
          sp_q    <= ssp_i;
          sr_q    <= (sr_i & ~SR_S_MASK) | (s_cur ? SR_S_MASK : 16'h0000);
          st_q    <= ST_VEC;
        end
        ST_VEC: begin
          // phase 2: vector number; pre-decrement for the first push
          vec_q <= vec_d;
          idx_q <= '0;
          if (is_reset) begin
            st_q <= ST_FETCH;
          end else begin
            sp_q <= sp_q - ADDR_W'(2);
            st_q <= ST_PUSH;
          end
        end
        ST_PUSH: if (mem_ack_i) begin
          if (idx_q == 2'd2) begin
            idx_q <= '0;
            st_q  <= ST_FETCH;
          end else begin
            idx_q <= idx_q + 2'd1;
            sp_q  <= sp_q - ADDR_W'(2);
          end
        end
        ST_FETCH: if (mem_ack_i) begin
          fetch_q <= {fetch_q[FETCH_W-WORD_W-1:0], mem_rdata_i};
          if (idx_q == last_idx) st_q <= ST_FIN;
          else                   idx_q <= idx_q + 2'd1;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = (st_q == ST_FIN);
  assign mem_req_o    = (st_q == ST_PUSH) || (st_q == ST_FETCH);
  assign supervisor_o = s_cur;
  assign new_pc_o     = fetch_q[31:0];
  assign new_ssp_o    = is_reset ? fetch_q[32 +: ADDR_W] : sp_q;
  assign new_sr_o     = is_reset ? SR_RESET : (sr_q | SR_S_MASK);
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              supervisor_o,
  input logic [15:0]       new_sr_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [2:0]        mem_space_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [15:0]       mem_wdata_o,
  input logic              mem_ack_i
);
  // R7
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)
                                && $stable(mem_we_o) && $stable(mem_space_o));

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o && !done_o);

  // R8
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o |=> busy_o);

  // R4
  push_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_space_o == 3'd5);

  // R6
  reset_nowrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_space_o == 3'd6 |-> !mem_we_o);

  // R5
  done_sr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> new_sr_o[13]);

  // R10
  priv_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(supervisor_o) |-> $past(req_i && !busy_o));
endmodule

bind exc_entry_seq exc_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .supervisor_o (supervisor_o),
  .new_sr_o     (new_sr_o),
  .mem_req_o    (mem_req_o),
  .mem_we_o     (mem_we_o),
  .mem_space_o  (mem_space_o),
  .mem_addr_o   (mem_addr_o),
  .mem_wdata_o  (mem_wdata_o),
  .mem_ack_i    (mem_ack_i)
);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;

  typedef struct packed {
    logic [3:0]    cause;
    logic [7:0]    ev;
    logic [15:0]   sr;
    logic [31:0]   pc;
    logic [AW-1:0] sp;
    logic [1:0]    lat;
    logic          pester;
    logic [7:0]    vec;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{4'd3,  8'h00, 16'h0000, 32'h0001_2344, 24'h00_1000, 2'd0, 1'b0, 8'd4},
    '{4'd1,  8'h00, 16'h2704, 32'h00FF_FFFE, 24'h00_8000, 2'd2, 1'b0, 8'd2},
    '{4'd9,  8'h11, 16'h001F, 32'hABCD_0010, 24'h01_0002, 2'd1, 1'b0, 8'd10},
    '{4'd10, 8'h40, 16'h2000, 32'h0000_0400, 24'h00_0100, 2'd0, 1'b1, 8'd64},
    '{4'd8,  8'h00, 16'h8000, 32'h0040_0000, 24'hFF_FFF0, 2'd3, 1'b0, 8'd9},
    '{4'd6,  8'h00, 16'h2010, 32'h1234_5678, 24'h00_0800, 2'd1, 1'b0, 8'd7},
    '{4'd15, 8'hFF, 16'h0700, 32'h0000_0002, 24'h00_2000, 2'd0, 1'b0, 8'd255},
    '{4'd5,  8'h00, 16'h0000, 32'h0000_1000, 24'h00_0006, 2'd2, 1'b0, 8'd6}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, sr_wr = 1'b0;
  logic [3:0]    cause = '0;
  logic [7:0]    ext = '0;
  logic [15:0]   sr_in = '0, sr_wdata = '0;
  logic [31:0]   pc_in = '0;
  logic [AW-1:0] ssp_in = '0;
  logic busy, done, supervisor, mem_req, mem_we;
  logic mem_ack = 1'b0;
  logic [31:0]   new_pc;
  logic [AW-1:0] new_ssp, mem_addr;
  logic [15:0]   new_sr, mem_wdata, mem_rdata;
  logic [2:0]    mem_space;

  int n_tests = 0, n_fail = 0;
  int cur_lat = 0, n_log = 0, hold_err = 0;
  int first_k, done_k, n_done;
  logic busy1, busy_post;
  logic [31:0]   got_pc;
  logic [AW-1:0] got_ssp;
  logic [15:0]   got_sr;
  logic [AW-1:0] l_addr [8];
  logic          l_we [8];
  logic [2:0]    l_space [8];
  logic [15:0]   l_data [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] rd(input logic [AW-1:0] a);
    return a[15:0] ^ 16'h5A3C;
  endfunction

  assign mem_rdata = rd(mem_addr);

  exc_entry_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .cause_i(cause), .ext_vec_i(ext),
    .sr_i(sr_in), .pc_i(pc_in), .ssp_i(ssp_in), .sr_wr_i(sr_wr), .sr_wdata_i(sr_wdata),
    .busy_o(busy), .done_o(done), .new_pc_o(new_pc), .new_ssp_o(new_ssp), .new_sr_o(new_sr),
    .supervisor_o(supervisor), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_space_o(mem_space),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // memory responder: acks after cur_lat wait cycles, logs accesses, checks hold (R7)
  initial begin
    int wc;
    logic [AW-1:0] first_addr;
    wc = 0;
    first_addr = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      if (mem_req) begin
        if (wc == 0) first_addr = mem_addr;
        else if (mem_addr != first_addr) hold_err++;
        if (wc >= cur_lat) begin
          mem_ack = 1'b1;
          if (n_log < 8) begin
            l_addr[n_log] = mem_addr; l_we[n_log] = mem_we;
            l_space[n_log] = mem_space; l_data[n_log] = mem_wdata;
          end
          n_log++;
          wc = 0;
        end else wc++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL R8 watchdog act=timeout exp=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic wr_sr(input logic [15:0] v);
    @(negedge clk);
    sr_wr = 1'b1; sr_wdata = v;
    @(negedge clk);
    sr_wr = 1'b0;
  endtask

  task automatic run_exc(input logic [3:0] c, input logic [7:0] ev, input logic [15:0] sr,
                         input logic [31:0] pc, input logic [AW-1:0] sp, input int lat,
                         input logic pester);
    cur_lat = lat; n_log = 0; hold_err = 0;
    first_k = 0; done_k = 0; n_done = 0; busy1 = 1'b0; busy_post = 1'b1;
    @(negedge clk);
    req = 1'b1; cause = c; ext = ev; sr_in = sr; pc_in = pc; ssp_in = sp;
    for (int k = 1; k < 400; k++) begin
      @(negedge clk);
      if (k == 1) begin
        busy1 = busy;
        req = pester;
        if (pester) begin
          cause = 4'd0; ext = ~ev; sr_in = ~sr; pc_in = ~pc; ssp_in = 24'h12_3456;
        end
      end
      if (k == 4) req = 1'b0;
      if (mem_req && first_k == 0) first_k = k;
      if (done) begin
        n_done++;
        if (done_k == 0) begin
          done_k = k; got_pc = new_pc; got_ssp = new_ssp; got_sr = new_sr;
        end
      end
      if (done_k != 0 && k == done_k + 1) busy_post = busy;
      if (done_k != 0 && k == done_k + 2) break;
    end
    req = 1'b0;
  endtask

  task automatic check_common(input string who);
    check({who, " R8 busy after accept"}, busy1, 1'b1);
    check({who, " R8 first access on 2nd edge"}, first_k, 2);
    check({who, " R8 single done pulse"}, n_done, 1);
    check({who, " R8 idle after done"}, busy_post, 1'b0);
    check({who, " R7 request held stable"}, hold_err, 0);
    check({who, " R10 supervisor after entry"}, supervisor, 1'b1);
  endtask

  task automatic check_normal(input vec_t t, input logic s_exp, input int i);
    logic [15:0]   saved;
    logic [AW-1:0] base;
    string who;
    who = $sformatf("vec%0d", i);
    saved = {t.sr[15:14], s_exp, t.sr[12:0]};
    base = AW'({t.vec, 2'b00});
    check({who, " R4 access count"}, n_log, 5);
    check({who, " R4 push low pc"}, {l_addr[0], l_we[0], l_space[0], l_data[0]},
          {t.sp - AW'(2), 1'b1, 3'd5, t.pc[15:0]});
    check({who, " R4 push high pc"}, {l_addr[1], l_we[1], l_space[1], l_data[1]},
          {t.sp - AW'(4), 1'b1, 3'd5, t.pc[31:16]});
    check({who, " R5 push saved sr"}, {l_addr[2], l_we[2], l_space[2], l_data[2]},
          {t.sp - AW'(6), 1'b1, 3'd5, saved});
    if (t.cause >= 4'd10) begin
      check({who, " R2 ext vector hi read"}, {l_addr[3], l_we[3], l_space[3]}, {base, 1'b0, 3'd5});
      check({who, " R2 ext vector lo read"}, {l_addr[4], l_we[4], l_space[4]}, {base + AW'(2), 1'b0, 3'd5});
    end else begin
      check({who, " R1 R3 vector hi read"}, {l_addr[3], l_we[3], l_space[3]}, {base, 1'b0, 3'd5});
      check({who, " R1 R3 vector lo read"}, {l_addr[4], l_we[4], l_space[4]}, {base + AW'(2), 1'b0, 3'd5});
    end
    check({who, " R3 new pc"}, got_pc, {rd(base), rd(base + AW'(2))});
    check({who, " R4 new ssp"}, got_ssp, t.sp - AW'(6));
    check({who, " R5 new sr"}, got_sr, saved | 16'h2000);
    if (t.pester) check({who, " R9 busy request ignored"}, n_log, 5);
    check_common(who);
  endtask

  initial begin
    logic s_exp;
    repeat (3) @(negedge clk);
    check("R8 reset busy/done/req low", {busy, done, mem_req}, 3'b000);
    check("R10 reset supervisor", supervisor, 1'b1);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      wr_sr(TBL[i].sr ^ 16'h2000);
      s_exp = ~TBL[i].sr[13];
      check($sformatf("vec%0d R10 status write S", i), supervisor, s_exp);
      run_exc(TBL[i].cause, TBL[i].ev, TBL[i].sr, TBL[i].pc, TBL[i].sp,
              int'(TBL[i].lat), TBL[i].pester);
      check_normal(TBL[i], s_exp, i);
    end

    // R6 reset entry
    run_exc(4'd0, 8'h77, 16'h0000, 32'hDEAD_BEEF, 24'h00_0400, 1, 1'b0);
    check("R6 reset access count", n_log, 4);
    for (int j = 0; j < 4; j++)
      check($sformatf("R6 reset read %0d", j), {l_addr[j], l_we[j], l_space[j]},
            {AW'(2 * j), 1'b0, 3'd6});
    check("R6 reset ssp", got_ssp, AW'({rd(AW'(0)), rd(AW'(2))}));
    check("R6 reset pc", got_pc, {rd(AW'(4)), rd(AW'(6))});
    check("R6 reset sr", got_sr, 16'h2700);
    check_common("rst");

    // R10 user state cannot be left by a status write
    wr_sr(16'h0000);
    check("R10 write clears S", supervisor, 1'b0);
    wr_sr(16'hFFFF);
    check("R10 write cannot set S", supervisor, 1'b0);
    run_exc(4'd4, 8'h00, 16'h2000, 32'h0000_0100, 24'h00_4000, 0, 1'b0);
    check("R5 stacked S from tracked bit", l_data[2], 16'h0000);
    check("R1 divide vector", l_addr[3], AW'(20));
    check_common("usr");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule